// File: doc/BRIEF.md
# Capture Channel Event Gate

This block controls one video capture channel. It sits between the capture datapath and the DMA engine. It holds a 32-bit control word and a small status word, both on a simple register bus. It decides when the channel may raise a DMA request, and when it raises its field and vertical interrupts. Capture starts blocked after power-up. Software clears the block bit and sets the enable bit. Requests then begin at the first frame start that follows.

Software starts a channel reset by writing 1 to the top bit of the control word. New requests stop at once. The sequencer waits until every issued DMA transfer has reported completion. It then asks the FIFO to flush and waits for the flush acknowledge. At that point every register returns to its power-up value and the reset bit clears itself. While the block bit is set, the FIFO flush line is held high. The status bits are frozen and no interrupt is raised.

Control word layout: bit 31 is reset (write 1 to start; reads 1 while busy), bit 30 is block (power-up 1), bit 15 is capture enable, and bits [CFG_W-1:0] are a general configuration field. All other bits are reserved. Status word (address 1) layout: bit 0 field-1 done, bit 1 field-2 done, bit 2 frame done.

Top module: `vcap_chan_gate`

## Requirements
- R1: After reset the control word reads 0x4000_0000, the status word reads 0, `dma_req` is 0 and `fifo_flush` is 1.
- R2: Reserved control bits read 0 and ignore writes; writing 0x7FFF_FFFF with CFG_W=8 reads back 0x4000_80FF.
- R3: Writing 0 to bit 31 starts nothing. Writing 1 starts a channel reset, and bit 31 reads 1 until the sequence ends.
- R4: From the cycle after the reset write, no new DMA request is raised, and the enable bit (bit 15) reads 0.
- R5: `fifo_flush` is raised by the reset only once the count of outstanding transfers is zero. After `flush_done`, bit 31 clears and all registers, the status word included, return to their R1 values.
- R6: While block (bit 30) is 1, no DMA request is raised and `fifo_flush` stays 1. The other control fields keep their written values.
- R7: While block is 1, the status bits do not change on strobes, and `irq_field` and `irq_vert` stay 0.
- R8: After block is cleared, no request is raised until the next `frame_start`; requests may follow it.
- R9: A request needs all of the following: enable is 1, `fifo_thresh` is 1, a frame start has been seen since block or reset was released, and no reset is active.
- R10: `dma_req` stays high until `dma_ack`. Each request counts as outstanding until a `dma_done` pulse. No request is raised while MAX_OUT transfers are outstanding.
- R11: Writing 1 to a status bit clears it and writing 0 leaves it alone. A strobe arriving in the same cycle as the clear wins, and the bit stays set.
- R12: With block at 0, any of the three completion strobes gives a one-cycle `irq_field` pulse on the next cycle, and `vblank_evt` gives a one-cycle `irq_vert` pulse in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| frame_start | input | 1 | Frame start strobe |
| field1_done | input | 1 | Field 1 complete strobe |
| field2_done | input | 1 | Field 2 complete strobe |
| frame_done | input | 1 | Frame complete strobe |
| vblank_evt | input | 1 | Vertical interval strobe |
| fifo_thresh | input | 1 | FIFO has reached its threshold |
| dma_req | output | 1 | DMA request, held until acknowledged |
| dma_ack | input | 1 | DMA acknowledge |
| dma_done | input | 1 | One issued transfer has completed |
| fifo_flush | output | 1 | FIFO flush request |
| flush_done | input | 1 | FIFO flush finished |
| irq_field | output | 1 | Field/frame complete interrupt pulse |
| irq_vert | output | 1 | Vertical interrupt pulse |

## Verification
The bench starts a reset while two transfers are still outstanding. A design that flushed early would raise `fifo_flush` before the second `dma_done`, and one that cleared bit 31 early would read back 0 during the flush wait. It clears block in the middle of a frame. A design that only looked at the block bit would raise a request before the next frame start. It also fills the outstanding limit, and it collides a status clear with a strobe, where a clear-wins design would lose the bit. A per-cycle interrupt scoreboard flags any pulse that appears while blocked, or that lasts longer than one cycle.

// File: rtl/vcg_pkg.sv
package vcg_pkg;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned BIT_RST = 31;
   localparam int unsigned BIT_BLK = 30;
   localparam int unsigned BIT_EN  = 15;
   localparam int unsigned ST_W    = 3;

   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_DRAIN = 2'd1,
      RS_FLUSH = 2'd2
   } rst_state_e;

   typedef struct packed {
      logic busy;
      logic blk;
      logic en;
   } ctl_view_t;
endpackage

// File: rtl/vcg_regs.sv
module vcg_regs
   import vcg_pkg::*;
#(
   parameter int unsigned CFG_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 addr,
   input  logic [WORD_W-1:0]    wdata,
   output logic [WORD_W-1:0]    rdata,
   input  logic                 rst_busy,
   input  logic                 rst_done,
   input  logic [ST_W-1:0]      st_set,
   output logic                 rst_req,
   output logic                 st_wr,
   output logic [ST_W-1:0]      status,
   output ctl_view_t            ctl
);
   logic             blk_q;
   logic             en_q;
   logic [CFG_W-1:0] cfg_q;
   logic             ctl_wr;

   assign ctl_wr  = wr_en && (addr == 1'b0);
   assign st_wr   = wr_en && (addr == 1'b1);
   assign rst_req = ctl_wr && wdata[BIT_RST] && !rst_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q <= 1'b1;
         en_q  <= 1'b0;
         cfg_q <= '0;
      end else if (rst_done) begin
         blk_q <= 1'b1;
         en_q  <= 1'b0;
         cfg_q <= '0;
      end else if (ctl_wr) begin
         blk_q <= wdata[BIT_BLK];
         en_q  <= wdata[BIT_EN] && !wdata[BIT_RST] && !rst_busy;
         cfg_q <= wdata[CFG_W-1:0];
      end
   end

   for (genvar i = 0; i < ST_W; i++) begin : g_st
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  status[i] <= 1'b0;
         else if (rst_done)           status[i] <= 1'b0;
         else if (st_set[i])          status[i] <= 1'b1;
         else if (st_wr && wdata[i])  status[i] <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == 1'b0) begin
         rdata[BIT_RST]     = rst_busy;
         rdata[BIT_BLK]     = blk_q;
         rdata[BIT_EN]      = en_q;
         rdata[CFG_W-1:0]   = cfg_q;
      end else begin
         rdata[ST_W-1:0]    = status;
      end
   end

   assign ctl = '{busy: rst_busy, blk: blk_q, en: en_q};
endmodule

// File: rtl/vcg_rstseq.sv
module vcg_rstseq
   import vcg_pkg::*;
#(
   parameter int unsigned MAX_OUT = 2,
   parameter int unsigned CNT_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rst_req,
   input  logic             dma_issue,
   input  logic             dma_done,
   input  logic             flush_done,
   output logic             busy,
   output logic             rst_done,
   output logic             flush_req,
   output logic [CNT_W-1:0] out_cnt
);
   rst_state_e state_q, state_d;
   logic       dec;

   assign dec = dma_done && (out_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 out_cnt <= '0;
      else if (dma_issue && !dec) out_cnt <= out_cnt + 1'b1;
      else if (dec && !dma_issue) out_cnt <= out_cnt - 1'b1;
   end

   always_comb begin
      state_d  = state_q;
      rst_done = 1'b0;
      unique case (state_q)
         RS_IDLE:  if (rst_req) state_d = RS_DRAIN;
         RS_DRAIN: if (out_cnt == '0) state_d = RS_FLUSH;
         RS_FLUSH: if (flush_done) begin
            state_d  = RS_IDLE;
            rst_done = 1'b1;
         end
         default:  state_d = RS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= RS_IDLE;
      else        state_q <= state_d;
   end

   assign busy      = (state_q != RS_IDLE);
   assign flush_req = (state_q == RS_FLUSH);
endmodule

// File: rtl/vcg_evgate.sv
module vcg_evgate
   import vcg_pkg::*;
#(
   parameter int unsigned MAX_OUT = 2,
   parameter int unsigned CNT_W   = 2,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ctl_view_t        ctl,
   input  logic             frame_start,
   input  logic             fifo_thresh,
   input  logic             dma_ack,
   input  logic [CNT_W-1:0] out_cnt,
   input  logic [ST_W-1:0]  st_evt,
   input  logic             vblank_evt,
   output logic             dma_req,
   output logic             dma_issue,
   output logic [ST_W-1:0]  st_set,
   output logic             irq_field,
   output logic             irq_vert
);
   logic sync_q;
   logic room;
   logic fld_ev;
   logic vrt_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    sync_q <= 1'b0;
      else if (ctl.blk || ctl.busy)  sync_q <= 1'b0;
      else if (frame_start)          sync_q <= 1'b1;
   end

   assign room      = (out_cnt < CNT_W'(MAX_OUT));
   assign dma_issue = ctl.en && !ctl.blk && !ctl.busy && sync_q &&
                      fifo_thresh && !dma_req && room;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dma_req <= 1'b0;
      else if (dma_issue) dma_req <= 1'b1;
      else if (dma_ack)   dma_req <= 1'b0;
   end

   assign st_set = ctl.blk ? '0 : st_evt;
   assign fld_ev = |st_set;
   assign vrt_ev = vblank_evt && !ctl.blk;

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_field <= 1'b0;
            irq_vert  <= 1'b0;
         end else begin
            irq_field <= fld_ev;
            irq_vert  <= vrt_ev;
         end
      end
   end else begin : g_irq_comb
      assign irq_field = fld_ev;
      assign irq_vert  = vrt_ev;
   end
endmodule

// File: rtl/vcap_chan_gate.sv
module vcap_chan_gate
   import vcg_pkg::*;
#(
   parameter int unsigned CFG_W   = 8,
   parameter int unsigned MAX_OUT = 2,
   parameter bit          IRQ_REG = 1'b1,
   localparam int unsigned CNT_W  = $clog2(MAX_OUT + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        frame_start,
   input  logic        field1_done,
   input  logic        field2_done,
   input  logic        frame_done,
   input  logic        vblank_evt,
   input  logic        fifo_thresh,
   output logic        dma_req,
   input  logic        dma_ack,
   input  logic        dma_done,
   output logic        fifo_flush,
   input  logic        flush_done,
   output logic        irq_field,
   output logic        irq_vert
);
   if (CFG_W < 1 || CFG_W > 15) begin : g_bad_cfg
      $error("CFG_W must lie in 1..15");
   end
   if (MAX_OUT < 1) begin : g_bad_out
      $error("MAX_OUT must be at least 1");
   end

   ctl_view_t        ctl;
   logic             rst_req, busy, rst_done, flush_req;
   logic             dma_issue, st_wr;
   logic [CNT_W-1:0] out_cnt;
   logic [ST_W-1:0]  st_set, status;

   vcg_regs #(.CFG_W(CFG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .rst_busy(busy),
      .rst_done(rst_done), .st_set(st_set), .rst_req(rst_req),
      .st_wr(st_wr), .status(status), .ctl(ctl)
   );

   vcg_rstseq #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_rstseq (
      .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .dma_issue(dma_issue),
      .dma_done(dma_done), .flush_done(flush_done), .busy(busy),
      .rst_done(rst_done), .flush_req(flush_req), .out_cnt(out_cnt)
   );

   vcg_evgate #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_evgate (
      .clk(clk), .rst_n(rst_n), .ctl(ctl), .frame_start(frame_start),
      .fifo_thresh(fifo_thresh), .dma_ack(dma_ack), .out_cnt(out_cnt),
      .st_evt({frame_done, field2_done, field1_done}),
      .vblank_evt(vblank_evt), .dma_req(dma_req), .dma_issue(dma_issue),
      .st_set(st_set), .irq_field(irq_field), .irq_vert(irq_vert)
   );

   assign fifo_flush = ctl.blk | flush_req;
endmodule

// File: rtl/vcap_chan_gate_chk.sv
module vcap_chan_gate_chk #(
   parameter int unsigned MAX_OUT = 2,
   parameter int unsigned CNT_W   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dma_req,
   input logic             dma_ack,
   input logic             fifo_flush,
   input logic             blk,
   input logic             busy,
   input logic             st_wr,
   input logic [CNT_W-1:0] out_cnt,
   input logic [2:0]       status
);
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req && !dma_ack |=> dma_req);

   a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      out_cnt <= CNT_W'(MAX_OUT));

   a_r4_no_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req) |-> !$past(busy));

   a_r6_no_issue_blk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req) |-> !$past(blk));

   a_r5_flush_drained: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush && !blk |-> out_cnt == '0);

   a_r7_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      blk && !busy && !st_wr |=> $stable(status));
endmodule

bind vcap_chan_gate vcap_chan_gate_chk #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
   .fifo_flush(fifo_flush), .blk(ctl.blk), .busy(busy), .st_wr(st_wr),
   .out_cnt(out_cnt), .status(status)
);

// File: tb/vcap_chan_gate_bench.sv
module vcap_chan_gate_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_addr = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        frame_start = 0, field1_done = 0, field2_done = 0, frame_done = 0;
   logic        vblank_evt = 0, fifo_thresh = 0, dma_ack = 0, dma_done = 0, flush_done = 0;
   logic        dma_req, fifo_flush, irq_field, irq_vert;

   int n_chk = 0;
   int n_bad = 0;
   logic [1:0]  irq_q[$];
   logic [1:0]  irq_exp;
   logic [31:0] rv;

   always #(CLK_P/2) clk = ~clk;

   vcap_chan_gate u_vcap_chan_gate (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
      .field1_done(field1_done), .field2_done(field2_done), .frame_done(frame_done),
      .vblank_evt(vblank_evt), .fifo_thresh(fifo_thresh), .dma_req(dma_req),
      .dma_ack(dma_ack), .dma_done(dma_done), .fifo_flush(fifo_flush),
      .flush_done(flush_done), .irq_field(irq_field), .irq_vert(irq_vert)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic a, logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // which: {vblank, frame, field2, field1}; exp: expected {irq_field, irq_vert}
   task automatic evt(logic [3:0] which, logic [1:0] exp);
      {vblank_evt, frame_done, field2_done, field1_done} = which;
      irq_q.push_back(exp);
      @(negedge clk);
      {vblank_evt, frame_done, field2_done, field1_done} = '0;
   endtask

   task automatic pulse_fs();
      frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
   endtask

   task automatic pulse_ack();
      dma_ack = 1'b1; @(negedge clk); dma_ack = 1'b0;
   endtask

   task automatic pulse_done();
      dma_done = 1'b1; @(negedge clk); dma_done = 1'b0;
   endtask

   // interrupt scoreboard: one expected entry per strobe cycle, zero otherwise
   always begin
      @(posedge clk);
      #1;
      if (rst_n) begin
         if (irq_q.size() > 0) begin
            irq_exp = irq_q.pop_front();
            chk("R12/R7 irq pulse", {30'd0, irq_field, irq_vert}, {30'd0, irq_exp});
         end else if ({irq_field, irq_vert} != 2'b00) begin
            chk("R12 irq outside strobe cycle", {30'd0, irq_field, irq_vert}, 32'd0);
         end
      end
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1
      rd(0, rv); chk("R1 ctrl reset", rv, 32'h4000_0000);
      rd(1, rv); chk("R1 status reset", rv, 32'h0);
      chk("R1 dma_req reset", dma_req, 1'b0);
      chk("R1 fifo_flush reset", fifo_flush, 1'b1);

      // R2 and R3 (bit 31 written 0)
      wr(0, 32'h7FFF_FFFF);
      rd(0, rv); chk("R2/R3 reserved masked", rv, 32'h4000_80FF);
      wr(0, 32'h0000_80AA);
      rd(0, rv); chk("R6 block released", rv, 32'h0000_80AA);
      chk("R6 flush drops with block", fifo_flush, 1'b0);

      // R8/R9: nothing before a frame start
      fifo_thresh = 1'b1;
      cyc(5);
      chk("R8 no req before frame start", dma_req, 1'b0);
      pulse_fs();
      cyc(1);
      chk("R9 req after frame start", dma_req, 1'b1);
      cyc(3);
      chk("R10 req held until ack", dma_req, 1'b1);
      pulse_ack();
      cyc(1);
      chk("R10 second req", dma_req, 1'b1);
      pulse_ack();
      cyc(4);
      chk("R10 outstanding limit", dma_req, 1'b0);
      pulse_done();
      cyc(1);
      chk("R10 req after completion", dma_req, 1'b1);
      pulse_ack();

      // R11/R12 status and interrupts
      evt(4'b0001, 2'b10);
      rd(1, rv); chk("R12 field1 status", rv, 32'h1);
      evt(4'b0100, 2'b10);
      evt(4'b1000, 2'b01);
      evt(4'b0010, 2'b10);
      rd(1, rv); chk("R12 all status", rv, 32'h7);
      wr(1, 32'h2);
      rd(1, rv); chk("R11 w1c", rv, 32'h5);
      field1_done = 1'b1; reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h1;
      irq_q.push_back(2'b10);
      @(negedge clk);
      field1_done = 1'b0; reg_wr = 1'b0;
      rd(1, rv); chk("R11 set wins over clear", rv, 32'h5);

      // R3/R4/R5 reset with two transfers outstanding
      wr(0, 32'h8000_80AA);
      rd(0, rv); chk("R3/R4 busy, enable cleared", rv, 32'h8000_00AA);
      chk("R5 no flush while outstanding", fifo_flush, 1'b0);
      chk("R4 no req in reset", dma_req, 1'b0);
      pulse_done();
      cyc(2);
      chk("R5 still waiting one outstanding", fifo_flush, 1'b0);
      pulse_done();
      cyc(2);
      chk("R5 flush after drain", fifo_flush, 1'b1);
      rd(0, rv); chk("R3 bit31 during flush", rv[31], 1'b1);
      chk("R4 no req during flush", dma_req, 1'b0);
      flush_done = 1'b1; @(negedge clk); flush_done = 1'b0;
      rd(0, rv); chk("R5 ctrl restored", rv, 32'h4000_0000);
      rd(1, rv); chk("R5 status restored", rv, 32'h0);

      // R6/R7 blocked
      wr(0, 32'h4000_803C);
      pulse_fs();
      cyc(3);
      chk("R6 no req while blocked", dma_req, 1'b0);
      chk("R6 flush held while blocked", fifo_flush, 1'b1);
      evt(4'b0001, 2'b00);
      evt(4'b1000, 2'b00);
      evt(4'b0100, 2'b00);
      rd(1, rv); chk("R7 status frozen", rv, 32'h0);
      rd(0, rv); chk("R6 fields retained", rv, 32'h4000_803C);

      // R8 release mid-frame
      wr(0, 32'h0000_803C);
      chk("R6 flush released", fifo_flush, 1'b0);
      cyc(5);
      chk("R8 wait for next frame", dma_req, 1'b0);
      pulse_fs();
      cyc(1);
      chk("R8 req after next frame", dma_req, 1'b1);
      fifo_thresh = 1'b0;
      pulse_ack();
      cyc(3);
      chk("R9 no req below threshold", dma_req, 1'b0);
      pulse_done();
      wr(0, 32'h0000_003C);
      fifo_thresh = 1'b1;
      cyc(4);
      chk("R9 no req when disabled", dma_req, 1'b0);
      wr(0, 32'h0000_803C);
      cyc(2);
      chk("R9 req when enabled", dma_req, 1'b1);
      pulse_ack();
      fifo_thresh = 1'b0;
      cyc(3);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule